// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block is the combinational hazard controller for a five-stage integer pipeline (fetch, decode, execute, memory, writeback). In every cycle it looks at the two source register numbers of the instruction in the execute stage. It compares each of them with the destination register of the instruction now in the memory stage and with that of the instruction now in the writeback stage. From those comparisons it drives a 2-bit select for each ALU operand multiplexer. The select picks the register file value, the memory-stage result or the writeback-stage result.

The same block also detects a load followed directly by a dependent instruction. When the instruction in execute is a load, and its target register equals either source register of the instruction in decode, the block raises a stall. The stall freezes the program counter and the fetch/decode register for one cycle. During that cycle the block zeroes the control bits that would be passed into execute, so the slot becomes a bubble that writes no register, writes no memory and takes no branch. Only the two preceding instructions need comparing, because the register file writes in the first half of a cycle and reads in the second half.

Top module: `hazardUnit`

## Requirements
- R1: When the memory-stage instruction writes a register (memRegWrite=1), its destination memRd is nonzero, and memRd equals exRs, fwdSelA is 2'b10 (memory-stage result).
- R2: When R1 does not apply to exRs, and wbRegWrite=1 with wbRd nonzero and wbRd equal to exRs, fwdSelA is 2'b01 (writeback-stage result).
- R3: When both the memory-stage and the writeback-stage destinations qualify for the same source, the select is 2'b10: the younger memory-stage result wins.
- R4: A destination of register 0, or a deasserted write flag for that stage, never causes forwarding. With no qualifying match the select is 2'b00 (register file). The value 2'b11 is never produced.
- R5: fwdSelB follows the rules of R1 to R4 for exRt, independently of fwdSelA.
- R6: stallFront is 1 when exMemRead=1 and exRt equals idRs or idRt. Any register number counts, including 0.
- R7: stallFront is 0 whenever exMemRead=0, whatever the register numbers are.
- R8: While stallFront is 1, exCtrlNext is all zeros. Otherwise exCtrlNext equals idCtrl bit for bit.
- R9: All outputs depend only on the present inputs: there is no internal state, and outputs settle within the same cycle that the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exRs | input | REG_AW | First source register of the instruction in execute |
| exRt | input | REG_AW | Second source register of the instruction in execute; also its load target |
| exMemRead | input | 1 | Instruction in execute is a load |
| memRd | input | REG_AW | Destination register of the instruction in the memory stage |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | REG_AW | Destination register of the instruction in the writeback stage |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| idRs | input | REG_AW | First source register of the instruction in decode |
| idRt | input | REG_AW | Second source register of the instruction in decode |
| idCtrl | input | CTRL_W | Decoded control bits heading into execute |
| fwdSelA | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback stage |
| fwdSelB | output | 2 | Operand B select, same encoding |
| stallFront | output | 1 | Hold PC and fetch/decode register this cycle |
| exCtrlNext | output | CTRL_W | Control bits to load into the decode/execute register (zero on a bubble) |

## Verification
The bench first applies hand-picked patterns. These are a lone memory-stage match, a lone writeback-stage match, both matching the same source, matches on register 0 and matches with the write flag cleared. Each pattern separates one priority or qualification rule. A case where the two operands hit different stages shows that the selects are independent. The load cases put the load target on the decode rs, then on the decode rt, then clear the load flag, which isolates the interlock from forwarding. The bench then drives random traffic drawn from a four-register space, so that coincidences between stages are frequent, and checks every output against a behavioural model in each cycle.

// File: rtl/hzPkg.sv
package hzPkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  localparam int unsigned NUM_OPS = 2;

  // strobes from the compare logic to the select/bubble path
  typedef struct packed {
    logic [NUM_OPS-1:0] memHit;
    logic [NUM_OPS-1:0] wbHit;
    logic               loadUse;
  } hzStrobe_t;

endpackage

// File: rtl/hzCtrl.sv
module hzCtrl
  import hzPkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] exRs,
  input  logic [REG_AW-1:0] exRt,
  input  logic              exMemRead,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbRegWrite,
  input  logic [REG_AW-1:0] idRs,
  input  logic [REG_AW-1:0] idRt,
  output hzStrobe_t         strobe
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [NUM_OPS-1:0][REG_AW-1:0] exSrc;
  logic memQual;
  logic wbQual;

  assign exSrc[0] = exRs;
  assign exSrc[1] = exRt;

  // a stage only qualifies if it writes a real register
  assign memQual = memRegWrite && (memRd != ZERO_REG);
  assign wbQual  = wbRegWrite  && (wbRd  != ZERO_REG);

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_cmp
    assign strobe.memHit[op] = memQual && (memRd == exSrc[op]);
    assign strobe.wbHit[op]  = wbQual  && (wbRd  == exSrc[op]);
  end

  assign strobe.loadUse = exMemRead && ((exRt == idRs) || (exRt == idRt));

endmodule

// File: rtl/fwdPath.sv
module fwdPath
  import hzPkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  hzStrobe_t                 strobe,
  input  logic [CTRL_W-1:0]         idCtrl,
  output logic [NUM_OPS-1:0][1:0]   sel,
  output logic                      stallFront,
  output logic [CTRL_W-1:0]         exCtrlNext
);

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_sel
    always_comb begin
      if (strobe.memHit[op])      sel[op] = SEL_MEM;
      else if (strobe.wbHit[op])  sel[op] = SEL_WB;
      else                        sel[op] = SEL_RF;
    end
  end

  assign stallFront = strobe.loadUse;
  assign exCtrlNext = strobe.loadUse ? '0 : idCtrl;

  // R4
  always_comb begin
    sel_legal_chk: assert (sel[0] != 2'b11 && sel[1] != 2'b11);
  end

endmodule

// File: rtl/hazardUnit.sv
module hazardUnit
  import hzPkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned CTRL_W = 8
) (
  input  logic [REG_AW-1:0] exRs,
  input  logic [REG_AW-1:0] exRt,
  input  logic              exMemRead,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbRegWrite,
  input  logic [REG_AW-1:0] idRs,
  input  logic [REG_AW-1:0] idRt,
  input  logic [CTRL_W-1:0] idCtrl,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic              stallFront,
  output logic [CTRL_W-1:0] exCtrlNext
);

  hzStrobe_t               strobe;
  logic [NUM_OPS-1:0][1:0] sel;

  hzCtrl #(.REG_AW(REG_AW)) u_ctrl (
    .exRs(exRs), .exRt(exRt), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .idRs(idRs), .idRt(idRt), .strobe(strobe)
  );

  fwdPath #(.CTRL_W(CTRL_W)) u_path (
    .strobe(strobe), .idCtrl(idCtrl), .sel(sel),
    .stallFront(stallFront), .exCtrlNext(exCtrlNext)
  );

  assign fwdSelA = sel[0];
  assign fwdSelB = sel[1];

  always_comb begin
    // R3
    mem_priority_chk: assert (!(memRegWrite && memRd != '0 && memRd == exRs) || fwdSelA == 2'b10);
    // R5
    opb_mem_chk: assert (!(memRegWrite && memRd != '0 && memRd == exRt) || fwdSelB == 2'b10);
    // R4
    zero_reg_chk: assert (!(exRs == '0) || fwdSelA == 2'b00);
    // R6
    load_use_chk: assert (!(exMemRead && (exRt == idRs || exRt == idRt)) || stallFront);
    // R8
    bubble_chk: assert (!stallFront || exCtrlNext == '0);
  end

endmodule

// File: tb/hazardUnit_tb.sv
module hazardUnit_tb;
  localparam int REG_AW = 5;
  localparam int CTRL_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [REG_AW-1:0] exRs, exRt, memRd, wbRd, idRs, idRt;
  logic exMemRead, memRegWrite, wbRegWrite;
  logic [CTRL_W-1:0] idCtrl;
  logic [1:0] fwdSelA, fwdSelB;
  logic stallFront;
  logic [CTRL_W-1:0] exCtrlNext;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hazardUnit #(.REG_AW(REG_AW), .CTRL_W(CTRL_W)) u_dut (
    .exRs(exRs), .exRt(exRt), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .idRs(idRs), .idRt(idRt), .idCtrl(idCtrl),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stallFront(stallFront), .exCtrlNext(exCtrlNext)
  );

  function automatic int refSel(int src);
    if (memRegWrite && memRd != 0 && int'(memRd) == src) return 2;
    if (wbRegWrite && wbRd != 0 && int'(wbRd) == src) return 1;
    return 0;
  endfunction

  function automatic string refTag(int src);
    bit m = memRegWrite && memRd != 0 && int'(memRd) == src;
    bit w = wbRegWrite && wbRd != 0 && int'(wbRd) == src;
    if (m && w) return "R3";
    if (m) return "R1";
    if (w) return "R2";
    return "R4";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R9: inputs change after a rising edge, outputs are compared 2 ns later in the same cycle
  task automatic compareAll();
    bit ld;
    #2;
    ld = exMemRead && (exRt == idRs || exRt == idRt);
    check({refTag(int'(exRs)), " selA"}, int'(fwdSelA), refSel(int'(exRs)));
    check({refTag(int'(exRt)), " R5 selB"}, int'(fwdSelB), refSel(int'(exRt)));
    check(exMemRead ? "R6 stall" : "R7 stall", int'(stallFront), int'(ld));
    check("R8 ctrl", int'(exCtrlNext), ld ? 0 : int'(idCtrl));
  endtask

  task automatic drive(int rs, int rt, int ld, int mrd, int mw, int wrd, int ww,
                       int irs, int irt, int ctl);
    @(posedge clk);
    exRs = REG_AW'(rs); exRt = REG_AW'(rt); exMemRead = ld[0];
    memRd = REG_AW'(mrd); memRegWrite = mw[0];
    wbRd = REG_AW'(wrd); wbRegWrite = ww[0];
    idRs = REG_AW'(irs); idRt = REG_AW'(irt); idCtrl = CTRL_W'(ctl);
    compareAll();
  endtask

  initial begin
    exRs = '0; exRt = '0; exMemRead = 0; memRd = '0; memRegWrite = 0;
    wbRd = '0; wbRegWrite = 0; idRs = '0; idRt = '0; idCtrl = '0;
    // idle state
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1 memory-stage hit on A
    drive(3, 9, 0, 3, 1, 0, 0, 1, 2, 8'h11);
    // R2 writeback-stage hit on A
    drive(4, 9, 0, 6, 1, 4, 1, 1, 2, 8'h22);
    // R3 both stages hit same source
    drive(5, 5, 0, 5, 1, 5, 1, 1, 2, 8'h33);
    // R4 register 0 never forwarded
    drive(0, 0, 0, 0, 1, 0, 1, 1, 2, 8'h44);
    // R4 write flag low: mem ignored, falls back to register file
    drive(7, 7, 0, 7, 0, 7, 0, 1, 2, 8'h55);
    // R4 mem flag low but wb qualifies
    drive(7, 8, 0, 7, 0, 7, 1, 1, 2, 8'h56);
    // R5 independent operands
    drive(1, 2, 0, 1, 1, 2, 1, 3, 4, 8'h66);
    // R6 load target equals id rs, then id rt, then register 0
    drive(1, 7, 1, 0, 0, 0, 0, 7, 3, 8'hA5);
    drive(1, 7, 1, 0, 0, 0, 0, 3, 7, 8'hA5);
    drive(1, 0, 1, 0, 0, 0, 0, 0, 3, 8'hA5);
    // R7 same registers, not a load
    drive(1, 7, 0, 0, 0, 0, 0, 7, 7, 8'hA5);
    // R8 no stall passes control through
    drive(1, 7, 1, 0, 0, 0, 0, 2, 3, 8'hFF);
    // random traffic in a small register space
    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 255));
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule